// File: doc/BRIEF.md
# Synchronous RAM with Clearable Read Path

This block is a single-clock RAM whose read path can be forced to zero at any moment by an active-high asynchronous clear, `clr_out`. The clear acts only on the read side. It forces the output latch to zero and, when the extra output register is built, that register too. In simple dual-port builds it also resets the registered read address. The stored words are never changed. All inputs pass through an input register stage, and writes are committed to the array one edge after capture.

The `DUAL_PORT` parameter picks the variant. With `DUAL_PORT=1` there are independent write and read addresses. With `DUAL_PORT=0` there is one shared address, taken from `wr_addr`, and `rd_addr` is ignored. `OUT_REG` adds a second output stage.

After a clear, the output stays at zero until a fresh read moves through the output path. `rd_en` starts a read. `out_en` qualifies the edge that loads the visible output stage, so an output that has been cleared only recovers on an edge where `out_en` is high.

Top module: `clr_out_ram`

## Requirements
- R1: A read presented with `rd_en=1` is captured on the next rising edge. The data reaches `rd_q` one edge later with `OUT_REG=0`, or two edges later with `OUT_REG=1`, provided `out_en=1` on the edge that loads `rd_q`.
- R2: While `clr_out` is high, `rd_q` is zero, and it becomes zero as soon as `clr_out` rises, without waiting for a clock edge. This holds in both output configurations.
- R3: A clear leaves every stored word unchanged. A word read after a clear equals the value last written to it.
- R4: Once `clr_out` is released, `rd_q` stays zero until a read started with `rd_en=1` has propagated to the output. It never shows the value it held before the clear.
- R5: With `DUAL_PORT=1`, a clear resets the registered read address to 0. A read already captured before the clear therefore returns word 0.
- R6: With `DUAL_PORT=0`, the clear leaves the shared address register alone. A read captured around a clear returns the addressed word.
- R7: The clear never affects the write-side input registers. A write captured just before or during a clear is still committed.
- R8: When no read has been started, `rd_q` holds its value on every edge.
- R9: The stage driving `rd_q` only loads on an edge where `out_en=1`. With `out_en=0`, `rd_q` holds, and after a clear it stays at zero.
- R10: A read of the same address that is being written on the same edge returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| clr_out | input | 1 | Active-high asynchronous clear of the read path |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address; also the shared address when DUAL_PORT=0 |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address (used only when DUAL_PORT=1) |
| out_en | input | 1 | Load qualifier for the stage driving rd_q |
| rd_q | output | DATA_W | Read data |

## Verification
The assertions assume that `clr_out` changes away from the rising edge and that each pulse spans at least one rising edge. Under that assumption, any edge that falls inside the clear window disables the clocked properties. The stimulus raises and lowers `clr_out` only at falling edges and holds each pulse across at least one full cycle, including the sparse clear pulses mixed into the random phase. Every other input is also driven at the falling edge, so the inputs sampled on each rising edge are stable.

// File: rtl/clr_ram_pkg.sv
package clr_ram_pkg;

  // Edges from read-address capture to the edge that loads rd_q.
  function automatic int unsigned read_latency(int unsigned out_reg);
    return 32'd1 + ((out_reg != 0) ? 32'd1 : 32'd0);
  endfunction

  // Whether the clear reaches the registered read address.
  function automatic bit raddr_clearable(int unsigned dual_port);
    return dual_port != 0;
  endfunction

  function automatic int unsigned depth_of(int unsigned addr_w);
    return 32'd1 << addr_w;
  endfunction

endpackage

// File: rtl/clr_ram_in_stage.sv
module clr_ram_in_stage #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DUAL_PORT = 1
) (
  input  logic              clk,
  input  logic              clr_out,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en_q,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [DATA_W-1:0] wr_data_q,
  output logic              rd_en_q,
  output logic [ADDR_W-1:0] rd_addr_q
);

  // Write side and read request: untouched by the clear in every mode.
  always_ff @(posedge clk) begin
    wr_en_q   <= wr_en;
    wr_addr_q <= wr_addr;
    wr_data_q <= wr_data;
    rd_en_q   <= rd_en;
  end

  generate
    if (clr_ram_pkg::raddr_clearable(DUAL_PORT)) begin : g_dual
      logic [ADDR_W-1:0] raddr_r;
      always_ff @(posedge clk or posedge clr_out) begin
        if (clr_out)    raddr_r <= '0;
        else if (rd_en) raddr_r <= rd_addr;
      end
      assign rd_addr_q = raddr_r;
    end else begin : g_single
      logic unused_sp_inputs;
      assign unused_sp_inputs = ^{rd_addr, clr_out};
      assign rd_addr_q = wr_addr_q;
    end
  endgenerate

endmodule

// File: rtl/clr_ram_array.sv
module clr_ram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  localparam int unsigned DEPTH = clr_ram_pkg::depth_of(ADDR_W);

  // No clear input: contents change only through the write port.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Combinational look-up; the output stage samples it on the same edge
  // as a pending write, so it sees the old word.
  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/clr_ram_out_stage.sv
module clr_ram_out_stage #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OUT_REG = 1
) (
  input  logic              clk,
  input  logic              clr_out,
  input  logic              out_en,
  input  logic              rd_en_q,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_q,
  output logic              q_upd
);

  logic [DATA_W-1:0] lat_r;
  logic              lat_ld;

  // Without an output register the latch is the visible stage and needs out_en.
  assign lat_ld = rd_en_q && ((OUT_REG != 0) || out_en);

  always_ff @(posedge clk or posedge clr_out) begin
    if (clr_out)     lat_r <= '0;
    else if (lat_ld) lat_r <= rd_word;
  end

  generate
    if (OUT_REG != 0) begin : g_oreg
      logic              lat_fresh;
      logic [DATA_W-1:0] oreg_r;
      logic              oreg_ld;

      always_ff @(posedge clk or posedge clr_out) begin
        if (clr_out) lat_fresh <= 1'b0;
        else         lat_fresh <= lat_ld;
      end

      assign oreg_ld = out_en && lat_fresh;

      always_ff @(posedge clk or posedge clr_out) begin
        if (clr_out)      oreg_r <= '0;
        else if (oreg_ld) oreg_r <= lat_r;
      end

      assign rd_q  = oreg_r;
      assign q_upd = oreg_ld;
    end else begin : g_latch
      assign rd_q  = lat_r;
      assign q_upd = lat_ld;
    end
  endgenerate

endmodule

// File: rtl/clr_out_ram.sv
module clr_out_ram #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned OUT_REG   = 1,
  parameter int unsigned DUAL_PORT = 1
) (
  input  logic              clk,
  input  logic              clr_out,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_q
);

  // Named internal events, also used by the bound checker.
  logic              wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              rd_en_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rd_word;
  logic              q_upd;

  clr_ram_in_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUAL_PORT(DUAL_PORT)
  ) in_i (
    .clk(clk), .clr_out(clr_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en_q(wr_en_q), .wr_addr_q(wr_addr_q), .wr_data_q(wr_data_q),
    .rd_en_q(rd_en_q), .rd_addr_q(rd_addr_q)
  );

  clr_ram_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) arr_i (
    .clk(clk), .wr_en(wr_en_q), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
    .rd_addr(rd_addr_q), .rd_word(rd_word)
  );

  clr_ram_out_stage #(
    .DATA_W(DATA_W), .OUT_REG(OUT_REG)
  ) out_i (
    .clk(clk), .clr_out(clr_out), .out_en(out_en),
    .rd_en_q(rd_en_q), .rd_word(rd_word),
    .rd_q(rd_q), .q_upd(q_upd)
  );

endmodule

// File: rtl/clr_ram_chk.sv
module clr_ram_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned OUT_REG   = 1,
  parameter int unsigned DUAL_PORT = 1
) (
  input logic              clk,
  input logic              clr_out,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic              out_en,
  input logic [DATA_W-1:0] rd_q,
  input logic              q_upd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] wr_addr_q,
  input logic [ADDR_W-1:0] rd_addr_q
);

  localparam int unsigned LAT = clr_ram_pkg::read_latency(OUT_REG);

  logic              started = 1'b0;
  logic [ADDR_W-1:0] prev_waddr;

  always_ff @(posedge clk) begin
    started    <= 1'b1;
    prev_waddr <= wr_addr;
  end

  // R2: output reads zero on every edge inside a clear.
  always_ff @(posedge clk) begin
    if (clr_out) begin
      p_clear_zero_r2: assert (rd_q == '0)
        else $error("rd_q not zero during clear");
    end
  end

  // R7: write-side address register follows the port through clears.
  always_ff @(posedge clk) begin
    if (started) begin
      p_waddr_kept_r7: assert (wr_addr_q == prev_waddr)
        else $error("write address register disturbed");
    end
  end

  generate
    if (DUAL_PORT != 0) begin : g_dp_chk
      // R5: read address register is zero while the clear is high.
      always_ff @(posedge clk) begin
        if (clr_out) begin
          p_raddr_zero_r5: assert (rd_addr_q == '0)
            else $error("read address not cleared");
        end
      end
    end else begin : g_sp_chk
      // R6: shared address keeps tracking the port, clear or not.
      always_ff @(posedge clk) begin
        if (started && clr_out) begin
          p_addr_kept_r6: assert (rd_addr_q == prev_waddr)
            else $error("shared address disturbed by clear");
        end
      end
    end
  endgenerate

  // R4 / R8: without an update event the output is frozen.
  p_hold_r4: assert property (@(posedge clk) disable iff (clr_out)
    !q_upd |=> $stable(rd_q));

  // R8: an update of rd_q always traces back to a read request.
  p_upd_after_read_r8: assert property (@(posedge clk) disable iff (clr_out)
    q_upd |-> $past(rd_en, LAT));

  // R9: the visible stage only loads with out_en high.
  p_upd_needs_oce_r9: assert property (@(posedge clk) disable iff (clr_out)
    q_upd |-> out_en);

  // R3 / R7: the array is written only for writes presented at the port.
  p_write_from_port_r7: assert property (@(posedge clk) disable iff (clr_out)
    mem_wr |-> $past(wr_en));

endmodule

bind clr_out_ram clr_ram_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG), .DUAL_PORT(DUAL_PORT)
) chk_i (
  .clk(clk), .clr_out(clr_out), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .out_en(out_en), .rd_q(rd_q), .q_upd(q_upd),
  .mem_wr(wr_en_q), .wr_addr_q(wr_addr_q), .rd_addr_q(rd_addr_q)
);

// File: tb/clr_out_ram_tb_top.sv
`timescale 1ns/1ps
module clr_out_ram_tb_top;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          clr = 1'b1;
  logic          we = 1'b0, re = 1'b0, oce = 1'b1;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] q_dp, q_sp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clr_out_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1), .DUAL_PORT(1)) dut_i (
    .clk(clk), .clr_out(clr), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .out_en(oce), .rd_q(q_dp));

  clr_out_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(0), .DUAL_PORT(0)) dut_sp_i (
    .clk(clk), .clr_out(clr), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .out_en(oce), .rd_q(q_sp));

  // ---------------- reference model, written from the requirements -------
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_we, m_re;
  logic [AW-1:0] m_wa, m_ra;
  logic [DW-1:0] m_wd;
  logic [DW-1:0] d_lat, d_q, s_q;
  logic          d_fresh;

  always @(posedge clk) begin
    m_we <= we; m_wa <= wa; m_wd <= wd; m_re <= re;
    if (m_we) ref_mem[m_wa] <= m_wd;
  end

  always @(posedge clk or posedge clr) begin
    if (clr) begin
      m_ra <= '0; d_lat <= '0; d_fresh <= 1'b0; d_q <= '0; s_q <= '0;
    end else begin
      if (re) m_ra <= ra;
      if (m_re) d_lat <= ref_mem[m_ra];
      d_fresh <= m_re;
      if (oce && d_fresh) d_q <= d_lat;
      if (m_re && oce) s_q <= ref_mem[m_wa];
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 29 + 7) ^ 8'h5A;
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: pass the rising edge, then compare both outputs at the falling edge.
  task automatic tick(string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, "dual/oreg vs model", q_dp, d_q);
    chk(req, "single/latch vs model", q_sp, s_q);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));

    // Reset state: output cleared (R2)
    repeat (3) tick("R2");
    chk("R2", "reset dual", q_dp, '0);
    chk("R2", "reset single", q_sp, '0);
    clr = 1'b0;

    // Fill memory; no reads, so outputs stay zero (R4)
    for (int a = 0; a < DEPTH; a++) begin
      we = 1'b1; wa = AW'(a); wd = pat(a);
      tick("R4");
    end
    we = 1'b0;
    tick("R4"); tick("R4");
    chk("R4", "no read after fill", q_dp, '0);

    // Latency (R1)
    wa = 6'd40; ra = 6'd40; re = 1'b1;
    tick("R1"); re = 1'b0;
    chk("R1", "single before latch edge", q_sp, '0);
    tick("R1");
    chk("R1", "single after one more edge", q_sp, pat(40));
    chk("R1", "dual not yet", q_dp, '0);
    tick("R1");
    chk("R1", "dual after two edges", q_dp, pat(40));

    // Read during write on same address returns old word (R10)
    we = 1'b1; wa = 6'd12; wd = 8'hEE; ra = 6'd12; re = 1'b1;
    tick("R10"); we = 1'b0; re = 1'b0;
    tick("R10");
    chk("R10", "single old word", q_sp, pat(12));
    tick("R10");
    chk("R10", "dual old word", q_dp, pat(12));
    ra = 6'd12; re = 1'b1;
    tick("R10"); re = 1'b0; tick("R10"); tick("R10");
    chk("R10", "dual new word later", q_dp, 8'hEE);

    // No read: output holds (R8)
    for (int i = 0; i < 4; i++) begin
      wa = AW'(i + 50); ra = AW'(i + 3);
      tick("R8");
      chk("R8", "dual holds", q_dp, 8'hEE);
      chk("R8", "single holds", q_sp, 8'hEE);
    end

    // Clear, stay zero, contents survive (R2, R4, R3)
    wa = 6'd20; ra = 6'd20; re = 1'b1;
    tick("R1"); re = 1'b0; tick("R1"); tick("R1");
    chk("R1", "dual word 20", q_dp, pat(20));
    clr = 1'b1;
    #1;
    chk("R2", "dual cleared at once", q_dp, '0);
    chk("R2", "single cleared at once", q_sp, '0);
    tick("R2");
    clr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick("R4");
      chk("R4", "dual stays zero", q_dp, '0);
      chk("R4", "single stays zero", q_sp, '0);
    end
    re = 1'b1;
    tick("R3"); re = 1'b0; tick("R3");
    chk("R3", "single word 20 kept", q_sp, pat(20));
    tick("R3");
    chk("R3", "dual word 20 kept", q_dp, pat(20));

    // Pending read across clear: dual resets address (R5), single keeps (R6)
    wa = 6'd5; ra = 6'd5; re = 1'b1;
    tick("R5");
    clr = 1'b1;
    tick("R5");
    clr = 1'b0; re = 1'b0; wa = 6'd33;
    tick("R6");
    chk("R6", "single reads addressed word", q_sp, pat(5));
    tick("R5");
    chk("R5", "dual reads word 0", q_dp, pat(0));

    // Writes around a clear still commit (R7)
    we = 1'b1; wa = 6'd30; wd = 8'hA5;
    tick("R7");
    clr = 1'b1; wa = 6'd31; wd = 8'h3C;
    tick("R7");
    clr = 1'b0; we = 1'b0;
    tick("R7");
    wa = 6'd30; ra = 6'd30; re = 1'b1;
    tick("R7");
    wa = 6'd31; ra = 6'd31;
    tick("R7");
    chk("R7", "single word 30", q_sp, 8'hA5);
    re = 1'b0;
    tick("R7");
    chk("R7", "single word 31", q_sp, 8'h3C);
    chk("R7", "dual word 30", q_dp, 8'hA5);
    tick("R7");
    chk("R7", "dual word 31", q_dp, 8'h3C);

    // out_en gating and recovery (R9)
    oce = 1'b0; clr = 1'b1;
    tick("R9");
    clr = 1'b0; wa = 6'd44; ra = 6'd44; re = 1'b1;
    tick("R9"); re = 1'b0;
    tick("R9"); tick("R9");
    chk("R9", "single stays zero without out_en", q_sp, '0);
    chk("R9", "dual stays zero without out_en", q_dp, '0);
    oce = 1'b1;
    tick("R9");
    chk("R9", "single needs a new read", q_sp, '0);
    chk("R9", "dual needs a new read", q_dp, '0);
    re = 1'b1;
    tick("R9"); re = 1'b0; tick("R9");
    chk("R9", "single recovers", q_sp, pat(44));
    tick("R9");
    chk("R9", "dual recovers", q_dp, pat(44));

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      bit rdw;
      string tag;
      rdw = ($urandom % 5) == 0;
      we  = ($urandom % 2) == 0;
      wa  = AW'($urandom);
      wd  = DW'($urandom);
      re  = ($urandom % 4) != 0;
      ra  = rdw ? wa : AW'($urandom);
      oce = ($urandom % 8) != 0;
      clr = ($urandom % 40) == 0;
      if (clr)       tag = "R2";
      else if (rdw)  tag = "R10";
      else if (!re)  tag = "R8";
      else if (!oce) tag = "R9";
      else           tag = "R1";
      tick(tag);
    end
    clr = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule